// File: doc/BRIEF.md
# Addressed Almost-Full Sector Multiplexer

This block places per-queue almost-full flags on a shared 8-bit status bus. It serves a buffer of up to 16 queues. The queues are grouped into sectors of eight, and the bus shows one sector at a time. A user picks the sector by raising a strobe together with an address word. The lowest address bits name the sector. The top three address bits name the device that should answer.

Several devices can share one bus. Each device compares the address's top bits with its own static 3-bit ID. Only the device that was last addressed drives the bus; every other device drops its output-enable. When eight or fewer queues are configured, no sector choice is needed. The bus then shows queues 0..7 whatever the strobe and address say.

A sector strobe that arrives in the same cycle as a write-queue selection breaks the usage rule. Such a strobe is discarded, and a one-cycle error pulse reports it.

Top module: `afull_sector_mux`

## Requirements
- R1: After reset the selected sector is 0, the bus reads all zeros, the error pulse is low, and output-enable is high exactly when the device ID is 0.
- R2: On a rising edge where the strobe is high, the write-queue request is low, address bits [6:4] equal the device ID, and more than eight queues are configured, address bit 0 becomes the sector. Bit 0 = 0 selects queues 0..7 and bit 0 = 1 selects queues 8..15.
- R3: The bus is registered. After each rising edge, bus bit b shows the flag of queue (sector*8 + b) as sampled at that edge. A new sector therefore appears on the first edge that captures it.
- R4: A new sector can be taken on every consecutive clock edge.
- R5: A bus bit whose queue number is not below the configured queue count reads 0.
- R6: When the configured count is 8 or less, bus bits 0..7 carry queues 0..7. The strobe and address do not change the sector in that state.
- R7: When the strobe and the write-queue request are both high at an edge, the strobe is ignored, and the error output is high for the one following cycle. In every other case it is low.
- R8: A valid strobe (write-queue request low) whose address bits [6:4] differ from the device ID clears output-enable. A matching one sets it. Output-enable holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_flags | input | 16 | Almost-full flag per queue, bit i for queue i |
| q_count | input | 5 | Number of configured queues, 1..16 |
| sec_strobe | input | 1 | Sector-select strobe |
| sec_addr | input | 7 | [6:4] device ID to address, [0] sector |
| dev_id | input | 3 | Static ID of this device |
| wq_sel | input | 1 | Write-queue selection in this cycle |
| stat_bus | output | 8 | Registered almost-full bus |
| stat_oe | output | 1 | Drive enable for the shared bus |
| sel_clash | output | 1 | One-cycle pulse after a strobe/write-select clash |

## Verification
Every output is registered, so each result is due right after the edge that samples its stimulus. A new sector, a flag change, an ownership change and a clash pulse all follow their edge by exactly one cycle. The bench drives inputs on the falling edge. At each rising edge it updates its model from those inputs, then compares all three outputs one nanosecond later. This keeps each check inside the cycle in which its result is due.

// File: rtl/afull_mux_pkg.sv
package afull_mux_pkg;
    // Default geometry of the status bus
    localparam int DEF_NUM_Q  = 16;
    localparam int DEF_BUS_W  = 8;
    localparam int DEF_ID_W   = 3;
    localparam int DEF_ADDR_W = 7;

    // Queue index shown on bus bit b for a given sector
    function automatic int queue_of(input int sector, input int bus_w, input int b);
        return sector * bus_w + b;
    endfunction
endpackage

// File: rtl/afull_sector_sel.sv
module afull_sector_sel #(
    parameter int NUM_Q  = afull_mux_pkg::DEF_NUM_Q,
    parameter int BUS_W  = afull_mux_pkg::DEF_BUS_W,
    parameter int ID_W   = afull_mux_pkg::DEF_ID_W,
    parameter int ADDR_W = afull_mux_pkg::DEF_ADDR_W,
    localparam int NUM_SEC = NUM_Q / BUS_W,
    localparam int SEC_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              wq_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              small_cfg,
    output logic [SEC_W-1:0]  sector,
    output logic              own,
    output logic              clash
);
    typedef struct packed {
        logic [SEC_W-1:0] sector;
        logic             own;
        logic             clash;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic       take_v;
    logic       id_hit_v;

    always_comb begin
        st_d     = st_q;
        id_hit_v = (addr[ADDR_W-1 -: ID_W] == dev_id);
        take_v   = strobe && !wq_sel;
        st_d.clash = strobe && wq_sel;
        if (take_v) begin
            st_d.own = id_hit_v;
            if (id_hit_v && !small_cfg) begin
                st_d.sector = addr[SEC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sector <= '0;
            st_q.own    <= (dev_id == '0);
            st_q.clash  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sector = st_q.sector;
    assign own    = st_q.own;
    assign clash  = st_q.clash;

    // R2: matching strobe in large config latches the sector bits
    assert_sector_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !wq_sel && !small_cfg && addr[ADDR_W-1 -: ID_W] == dev_id)
        |=> (sector == $past(addr[SEC_W-1:0])));

    // R7: a clash leaves the sector alone and pulses the error
    assert_clash_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && wq_sel) |=> (clash && $stable(sector) && $stable(own)));

    // R7: no error pulse without a clash one cycle earlier
    assert_clash_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strobe && wq_sel)) |=> !clash);

    // R8: a valid strobe for another device releases the bus
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !wq_sel && addr[ADDR_W-1 -: ID_W] != dev_id) |=> !own);

    // R6: small configuration never moves the sector
    assert_small_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        small_cfg |=> $stable(sector));
endmodule

// File: rtl/afull_flag_mux.sv
module afull_flag_mux #(
    parameter int NUM_Q = afull_mux_pkg::DEF_NUM_Q,
    parameter int BUS_W = afull_mux_pkg::DEF_BUS_W,
    localparam int NUM_SEC = NUM_Q / BUS_W,
    localparam int SEC_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int CNT_W   = $clog2(NUM_Q + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] flags,
    input  logic [CNT_W-1:0] count,
    input  logic [SEC_W-1:0] sector_next,
    input  logic             small_cfg,
    output logic [BUS_W-1:0] bus
);
    typedef struct packed {
        logic [BUS_W-1:0] bus;
    } mux_state_t;

    mux_state_t        st_d, st_q;
    logic [BUS_W-1:0]  lane_v;
    logic [SEC_W-1:0]  eff_sec;

    assign eff_sec = small_cfg ? '0 : sector_next;

    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        int q_idx;
        always_comb begin
            q_idx = afull_mux_pkg::queue_of(int'(eff_sec), BUS_W, b);
            if (q_idx < int'(count) && q_idx < NUM_Q) begin
                lane_v[b] = flags[q_idx];
            end else begin
                lane_v[b] = 1'b0;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.bus = lane_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus = st_q.bus;

    // R6: a full small configuration shows the low queues directly
    assert_small_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (small_cfg && int'(count) == BUS_W) |=> (bus == $past(flags[BUS_W-1:0])));

    // R5: a single configured queue leaves the upper bits at 0
    assert_unconfigured_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == 1) |=> (bus[BUS_W-1:1] == '0));
endmodule

// File: rtl/afull_sector_mux.sv
module afull_sector_mux #(
    parameter int NUM_Q  = afull_mux_pkg::DEF_NUM_Q,
    parameter int BUS_W  = afull_mux_pkg::DEF_BUS_W,
    parameter int ID_W   = afull_mux_pkg::DEF_ID_W,
    parameter int ADDR_W = afull_mux_pkg::DEF_ADDR_W,
    localparam int NUM_SEC = NUM_Q / BUS_W,
    localparam int SEC_W   = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int CNT_W   = $clog2(NUM_Q + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  q_flags,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              sec_strobe,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              wq_sel,
    output logic [BUS_W-1:0]  stat_bus,
    output logic              stat_oe,
    output logic              sel_clash
);
    logic             small_cfg;
    logic [SEC_W-1:0] sector_q;
    logic [SEC_W-1:0] sector_nx;
    logic             id_hit;

    assign small_cfg = (int'(q_count) <= BUS_W);
    assign id_hit    = (sec_addr[ADDR_W-1 -: ID_W] == dev_id);

    // Sector that the selector will hold after this edge, for the bus register
    assign sector_nx = (sec_strobe && !wq_sel && id_hit && !small_cfg)
                       ? sec_addr[SEC_W-1:0] : sector_q;

    afull_sector_sel #(
        .NUM_Q(NUM_Q), .BUS_W(BUS_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (sec_strobe),
        .wq_sel   (wq_sel),
        .addr     (sec_addr),
        .dev_id   (dev_id),
        .small_cfg(small_cfg),
        .sector   (sector_q),
        .own      (stat_oe),
        .clash    (sel_clash)
    );

    afull_flag_mux #(
        .NUM_Q(NUM_Q), .BUS_W(BUS_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (q_flags),
        .count      (q_count),
        .sector_next(sector_nx),
        .small_cfg  (small_cfg),
        .bus        (stat_bus)
    );

    // R3: the bus register and the selector agree after every edge
    assert_bus_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!small_cfg && int'(q_count) == NUM_Q) |=>
        (stat_bus == $past(q_flags[int'(sector_nx)*BUS_W +: BUS_W])));
endmodule

// File: tb/tb_afull_sector_mux.sv
module tb_afull_sector_mux;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] q_flags;
    logic [4:0]  q_count;
    logic        sec_strobe;
    logic [6:0]  sec_addr;
    logic [2:0]  dev_id;
    logic        wq_sel;
    logic [7:0]  stat_bus;
    logic        stat_oe;
    logic        sel_clash;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic       m_sec;
    logic       m_own;
    logic       m_err;
    logic [7:0] m_bus;

    always #4 clk = ~clk;

    afull_sector_mux dut (
        .clk(clk), .rst_n(rst_n), .q_flags(q_flags), .q_count(q_count),
        .sec_strobe(sec_strobe), .sec_addr(sec_addr), .dev_id(dev_id),
        .wq_sel(wq_sel), .stat_bus(stat_bus), .stat_oe(stat_oe),
        .sel_clash(sel_clash)
    );

    function automatic logic [7:0] exp_bus(input logic sec, input logic [15:0] f,
                                           input logic [4:0] cnt);
        logic [7:0] r;
        int s;
        s = (cnt <= 5'd8) ? 0 : int'(sec);
        for (int b = 0; b < 8; b++) begin
            r[b] = ((s * 8 + b) < int'(cnt)) ? f[s * 8 + b] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at falling edge, model at rising edge, compare 1 ns later
    task automatic step(input logic [15:0] f, input logic [4:0] cnt, input logic stb,
                        input logic [6:0] ad, input logic wq, input string req);
        @(negedge clk);
        q_flags = f; q_count = cnt; sec_strobe = stb; sec_addr = ad; wq_sel = wq;
        @(posedge clk);
        m_err = stb && wq;
        if (stb && !wq) begin
            m_own = (ad[6:4] == dev_id);
            if (m_own && cnt > 5'd8) m_sec = ad[0];
        end
        m_bus = exp_bus(m_sec, f, cnt);
        #1;
        check({req, " bus R3"}, stat_bus, m_bus);
        check({req, " oe R8"}, {7'd0, stat_oe}, {7'd0, m_own});
        check({req, " clash R7"}, {7'd0, sel_clash}, {7'd0, m_err});
    endtask

    task automatic do_reset(input logic [2:0] id);
        @(negedge clk);
        rst_n = 1'b0; dev_id = id;
        q_flags = 16'hFFFF; q_count = 5'd16; sec_strobe = 1'b0; sec_addr = '0; wq_sel = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("reset bus R1", stat_bus, 8'h00);
        check("reset oe R1", {7'd0, stat_oe}, {7'd0, id == 3'd0});
        check("reset clash R1", {7'd0, sel_clash}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        m_sec = 1'b0; m_own = (id == 3'd0); m_err = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        do_reset(3'd0);
        // R3: sector 0 then sector 1, full configuration
        step(16'hA55A, 5'd16, 1'b1, 7'b000_0000, 1'b0, "sector0 R2");
        step(16'hA55A, 5'd16, 1'b1, 7'b000_0001, 1'b0, "sector1 R2");
        // R4: back-to-back switching
        for (int i = 0; i < 6; i++)
            step(16'h3CC3 ^ 16'(i), 5'd16, 1'b1, {3'd0, 3'd0, 1'(i)}, 1'b0, "b2b R4");
        // R5: 10 queues, sector 1 upper bits zero
        step(16'hFFFF, 5'd10, 1'b1, 7'b000_0001, 1'b0, "partial R5");
        step(16'hFFFF, 5'd10, 1'b0, 7'b000_0000, 1'b0, "partial hold R5");
        // R6: small config ignores strobe to sector 1
        step(16'hFF5A, 5'd8, 1'b1, 7'b000_0001, 1'b0, "small R6");
        step(16'hFF5A, 5'd5, 1'b1, 7'b000_0000, 1'b0, "small mask R6");
        // R7: clash ignored
        step(16'h1234, 5'd16, 1'b1, 7'b000_0000, 1'b0, "pre-clash R2");
        step(16'h1234, 5'd16, 1'b1, 7'b000_0001, 1'b1, "clash R7");
        step(16'h1234, 5'd16, 1'b0, 7'b000_0001, 1'b0, "after clash R7");
        // R8: other device addressed releases, own address reclaims
        step(16'h8001, 5'd16, 1'b1, 7'b101_0001, 1'b0, "release R8");
        step(16'h8001, 5'd16, 1'b0, 7'b000_0000, 1'b0, "released hold R8");
        step(16'h8001, 5'd16, 1'b1, 7'b000_0001, 1'b0, "reclaim R8");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0] c;
            c = 5'(($urandom % 16) + 1);
            step(16'($urandom), c, 1'($urandom), {3'($urandom % 2), 3'($urandom), 1'($urandom)},
                 ($urandom % 5) == 0, "random R2");
        end
        // second device ID
        do_reset(3'd5);
        step(16'hF00F, 5'd16, 1'b1, 7'b101_0001, 1'b0, "id5 take R2");
        step(16'hF00F, 5'd16, 1'b1, 7'b000_0000, 1'b0, "id5 other R8");
        for (int i = 0; i < 300; i++) begin
            step(16'($urandom), 5'(($urandom % 16) + 1), 1'($urandom),
                 {(($urandom % 2) == 0) ? 3'd5 : 3'($urandom), 3'($urandom), 1'($urandom)},
                 ($urandom % 6) == 0, "random id5 R8");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule